// File: doc/BRIEF.md
# Segment-Aware Address Translation Front End

This block sits between a processor's address generation stage and its page-table cache in a 32-bit virtual address space that is split into segments. For each request it takes the virtual address, the access kind (instruction fetch, data read or data write), a misalignment flag, the processor status word, a small-page mode flag and the result of a page-table cache lookup. One clock later it returns either a physical address with a cacheability flag, or a fault code along with the values the exception logic writes into its address-reporting registers.

The two unmapped kernel windows bypass the lookup completely: the window base is stripped, and the cached window is legal only in kernel mode. Every other address is looked up. The block also drives the lookup page number to the cache in the same cycle. The matched entry holds two halves, and a virtual address bit chosen by the entry's page size selects between them. The block checks that half's valid and dirty bits and forms the physical address from the half's frame number and the entry's page-offset mask. The block does not store any entries and does not run any handler.

Top module: `xlat_front`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid`, `rsp_fault`, `rsp_paddr`, `rsp_uncached`, `rsp_badva`, `rsp_asid`, `rsp_vpn2` and `rsp_vpn2x` are all zero.
- R2: `rsp_mode` reports the operating mode decoded from `status_word`. The mode is kernel (0) if `status_word & 0x10000006` is nonzero or if bits [4:3] are 00. Otherwise bits [4:3] = 01 give supervisor (1), 10 give user (2) and 11 give undefined (3).
- R3: `look_vpn` equals `req_vaddr >> 11` (21 bits) in the same cycle, with its two low bits forced to zero when `small_pg` is 0.
- R4: An address with bits [31:29] = 100 (cached kernel window) or 101 (uncached kernel window) ignores the lookup inputs. It yields `rsp_paddr = vaddr & 0x1FFFFFFF`, with `rsp_uncached` = 0 for the 100 window and 1 for the 101 window.
- R5: In the 100 window, an access made in any mode other than kernel, or a misaligned access, raises an address error: code 1 for a fetch, code 2 for a data access, with `rsp_badva` = vaddr. The 101 window never faults.
- R6: A misaligned access outside the two kernel windows raises the address error of R5 (code 1 or 2), whatever the lookup result.
- R7: A lookup miss (`tlb_hit` = 0) on an aligned mapped access raises a refill fault: code 3 for a fetch, code 4 for a data access.
- R8: On a hit, the bit `vaddr[tlb_shift]` selects the odd half when it is 1 and the even half when it is 0. If the selected half's valid bit is clear, the access raises an invalid fault: code 5 for a fetch, code 6 for a data access.
- R9: A write (`req_kind` = 2) that hits a valid half whose dirty bit is clear raises a modified fault (code 7). A read (`req_kind` 1 or 3) or a fetch (`req_kind` 0) of the same half completes with no fault (code 0).
- R10: Faults with codes 3 to 7 report `rsp_badva` = vaddr, `rsp_asid` = `req_asid`, `rsp_vpn2` = `look_vpn >> 2` and `rsp_vpn2x` = `look_vpn & 3`. Codes 0, 1 and 2 report zero in `rsp_asid`, `rsp_vpn2` and `rsp_vpn2x`, and code 0 also reports zero in `rsp_badva`.
- R11: A mapped access with no fault returns `rsp_paddr` = ((frame << 12) with bits below `tlb_shift` cleared) | (vaddr & `tlb_offmask`), where frame is the selected half's frame number.
- R12: A response with no fault has `rsp_uncached` = 1 exactly when `(vaddr & 0xA0000000) == 0xA0000000`. A response with a fault has `rsp_paddr` = 0 and `rsp_uncached` = 0.
- R13: `rsp_valid` is `req_valid` delayed by one clock. The other response outputs load only when `req_valid` is high and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_misal | input | 1 | Address is misaligned for the access size |
| req_asid | input | ASID_W | Address-space identifier of the request |
| status_word | input | 32 | Processor status word |
| small_pg | input | 1 | Small-page lookup mode |
| look_vpn | output | 21 | Page number sent to the lookup cache |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_shift | input | SH_W | Page-shift amount of the entry (at least 12) |
| tlb_offmask | input | 32 | Page-offset mask of the entry |
| tlb_pfn_even | input | PFN_W | Frame number of the even half |
| tlb_pfn_odd | input | PFN_W | Frame number of the odd half |
| tlb_valid_even | input | 1 | Even half valid |
| tlb_valid_odd | input | 1 | Odd half valid |
| tlb_dirty_even | input | 1 | Even half writable |
| tlb_dirty_odd | input | 1 | Odd half writable |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 3 | Fault code (0 none) |
| rsp_paddr | output | PFN_W+12 | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_mode | output | 2 | Decoded operating mode |
| rsp_badva | output | 32 | Faulting virtual address |
| rsp_asid | output | ASID_W | Identifier reported with a lookup fault |
| rsp_vpn2 | output | 19 | Page-pair number for the entry-high and context registers |
| rsp_vpn2x | output | 2 | Low two bits of the lookup page number |

## Verification
The bench builds the block with its defaults: an 8-bit identifier, 20-bit frame numbers (a 32-bit physical address) and a 5-bit page shift. With these, both 4 KB pages (shift 12) and 16 KB pages (shift 14) can be driven. This exercises half selection from bit 12 and from bit 14, the clearing of frame bits below a larger shift, and both lookup page number forms. The full 32-bit address space is available, so each segment, including the mapped uncacheable top region, is covered.

// File: rtl/xlat_pkg.sv
// Shared constants and types for the translation front end.
// Assumes a 32-bit virtual address space with fixed kernel windows.
package xlat_pkg;
    localparam int VA_W     = 32;
    localparam int PAGE_LSB = 12;
    localparam int LOOK_LSB = 11;
    localparam int VPN_W    = VA_W - LOOK_LSB;
    localparam int VPN2_W   = VPN_W - 2;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_READ2 = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_SUPER  = 2'd1,
        MODE_USER   = 2'd2,
        MODE_UNDEF  = 2'd3
    } op_mode_t;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_ADDR_FETCH = 3'd1,
        FLT_ADDR_DATA  = 3'd2,
        FLT_MISS_FETCH = 3'd3,
        FLT_MISS_DATA  = 3'd4,
        FLT_INV_FETCH  = 3'd5,
        FLT_INV_DATA   = 3'd6,
        FLT_DIRTY_WR   = 3'd7
    } fault_t;
endpackage

// File: rtl/xlat_mode_dec.sv
// Decodes the operating mode from the status word.
// Assumes error/exception-level bits (mask 0x10000006) force kernel mode.
module xlat_mode_dec
    import xlat_pkg::*;
(
    input  logic [31:0] status,
    output op_mode_t    mode
);
    logic force_kern;
    logic unused_status;

    // Bits that override the mode field.
    assign force_kern    = (status & 32'h1000_0006) != 32'h0;
    assign unused_status = ^{status[31:29], status[27:5], status[0]};

    // Mode field decode with override.
    always_comb begin
        if (force_kern || status[4:3] == 2'b00) mode = MODE_KERNEL;
        else if (status[4:3] == 2'b01)          mode = MODE_SUPER;
        else if (status[4:3] == 2'b10)          mode = MODE_USER;
        else                                    mode = MODE_UNDEF;
    end
endmodule

// File: rtl/xlat_seg_class.sv
// Classifies a virtual address into the unmapped kernel windows and
// gives the direct physical address and the address-based cacheability.
// Assumes a 32-bit address; windows are 512 MB each.
module xlat_seg_class
    import xlat_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic [VA_W-1:0] va,
    output logic            in_kcached,
    output logic            in_kuncached,
    output logic [PA_W-1:0] direct_pa,
    output logic            addr_uncached
);
    // Window decode from the top three address bits.
    assign in_kcached   = va[31:29] == 3'b100;
    assign in_kuncached = va[31:29] == 3'b101;

    // Strip the window base.
    assign direct_pa = PA_W'({3'b000, va[28:0]});

    // Address-based uncacheable rule.
    assign addr_uncached = va[31] & va[29];
endmodule

// File: rtl/xlat_page_sel.sv
// Picks the even or odd half of a matched entry from the address bit at
// the page shift, and forms the physical address from that half's frame.
// Assumes shift >= PAGE_LSB; the offset mask covers the bits below shift.
module xlat_page_sel
    import xlat_pkg::*;
#(
    parameter int PFN_W = 20,
    parameter int SH_W  = 5,
    localparam int PA_W = PFN_W + PAGE_LSB
) (
    input  logic [VA_W-1:0]  va,
    input  logic [SH_W-1:0]  shift,
    input  logic [VA_W-1:0]  offmask,
    input  logic [PFN_W-1:0] pfn_even,
    input  logic [PFN_W-1:0] pfn_odd,
    input  logic             valid_even,
    input  logic             valid_odd,
    input  logic             dirty_even,
    input  logic             dirty_odd,
    output logic             half_valid,
    output logic             half_dirty,
    output logic [PA_W-1:0]  paddr
);
    logic             odd;
    logic [PFN_W-1:0] pfn;
    logic [PA_W-1:0]  base;
    logic [PA_W-1:0]  himask;

    // Half selection bit.
    assign odd = va[shift];

    // Per-half attributes.
    always_comb begin
        if (odd) begin
            pfn        = pfn_odd;
            half_valid = valid_odd;
            half_dirty = dirty_odd;
        end else begin
            pfn        = pfn_even;
            half_valid = valid_even;
            half_dirty = dirty_even;
        end
    end

    // Frame aligned to the page size, then merged with the offset.
    assign base   = {pfn, {PAGE_LSB{1'b0}}};
    assign himask = {PA_W{1'b1}} << shift;
    assign paddr  = (base & himask) | PA_W'(va & offmask);
endmodule

// File: rtl/xlat_fault_pri.sv
// Resolves the fault code by priority: window/mode, misalignment,
// lookup miss, invalid half, then write to a clean half.
// Assumes all inputs are valid in the same cycle.
module xlat_fault_pri
    import xlat_pkg::*;
(
    input  acc_kind_t kind,
    input  op_mode_t  mode,
    input  logic      misal,
    input  logic      in_kcached,
    input  logic      in_kuncached,
    input  logic      hit,
    input  logic      half_valid,
    input  logic      half_dirty,
    output fault_t    code
);
    logic is_fetch;
    logic is_write;

    assign is_fetch = kind == KIND_FETCH;
    assign is_write = kind == KIND_WRITE;

    // Priority chain.
    always_comb begin
        code = FLT_NONE;
        if (in_kcached) begin
            if (mode != MODE_KERNEL || misal)
                code = is_fetch ? FLT_ADDR_FETCH : FLT_ADDR_DATA;
        end else if (!in_kuncached) begin
            if (misal)
                code = is_fetch ? FLT_ADDR_FETCH : FLT_ADDR_DATA;
            else if (!hit)
                code = is_fetch ? FLT_MISS_FETCH : FLT_MISS_DATA;
            else if (!half_valid)
                code = is_fetch ? FLT_INV_FETCH : FLT_INV_DATA;
            else if (is_write && !half_dirty)
                code = FLT_DIRTY_WR;
        end
    end
endmodule

// File: rtl/xlat_front.sv
// Translation front end: kernel-window bypass, mode check, lookup page
// number generation, half selection and fault reporting, with one
// register stage on the response.
// Assumes the lookup result arrives in the same cycle as look_vpn.
module xlat_front
    import xlat_pkg::*;
#(
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    parameter int SH_W   = 5,
    localparam int PA_W  = PFN_W + PAGE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_misal,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [31:0]       status_word,
    input  logic              small_pg,
    output logic [VPN_W-1:0]  look_vpn,
    input  logic              tlb_hit,
    input  logic [SH_W-1:0]   tlb_shift,
    input  logic [VA_W-1:0]   tlb_offmask,
    input  logic [PFN_W-1:0]  tlb_pfn_even,
    input  logic [PFN_W-1:0]  tlb_pfn_odd,
    input  logic              tlb_valid_even,
    input  logic              tlb_valid_odd,
    input  logic              tlb_dirty_even,
    input  logic              tlb_dirty_odd,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_uncached,
    output logic [1:0]        rsp_mode,
    output logic [VA_W-1:0]   rsp_badva,
    output logic [ASID_W-1:0] rsp_asid,
    output logic [VPN2_W-1:0] rsp_vpn2,
    output logic [1:0]        rsp_vpn2x
);
    op_mode_t         mode;
    logic             in_kc, in_ku, addr_unc;
    logic [PA_W-1:0]  direct_pa, mapped_pa;
    logic             half_valid, half_dirty;
    fault_t           code;
    logic             tlb_flt;
    logic [PA_W-1:0]  nx_paddr;
    logic             nx_unc;

    // Lookup page number, coarse form clears the pair bits.
    assign look_vpn = small_pg ? req_vaddr[VA_W-1:LOOK_LSB]
                               : {req_vaddr[VA_W-1:LOOK_LSB+2], 2'b00};

    xlat_mode_dec u_mode (
        .status (status_word),
        .mode   (mode)
    );

    xlat_seg_class #(.PA_W(PA_W)) u_seg (
        .va            (req_vaddr),
        .in_kcached    (in_kc),
        .in_kuncached  (in_ku),
        .direct_pa     (direct_pa),
        .addr_uncached (addr_unc)
    );

    xlat_page_sel #(.PFN_W(PFN_W), .SH_W(SH_W)) u_page (
        .va         (req_vaddr),
        .shift      (tlb_shift),
        .offmask    (tlb_offmask),
        .pfn_even   (tlb_pfn_even),
        .pfn_odd    (tlb_pfn_odd),
        .valid_even (tlb_valid_even),
        .valid_odd  (tlb_valid_odd),
        .dirty_even (tlb_dirty_even),
        .dirty_odd  (tlb_dirty_odd),
        .half_valid (half_valid),
        .half_dirty (half_dirty),
        .paddr      (mapped_pa)
    );

    xlat_fault_pri u_flt (
        .kind         (acc_kind_t'(req_kind)),
        .mode         (mode),
        .misal        (req_misal),
        .in_kcached   (in_kc),
        .in_kuncached (in_ku),
        .hit          (tlb_hit),
        .half_valid   (half_valid),
        .half_dirty   (half_dirty),
        .code         (code)
    );

    // Faults from the lookup path carry the entry-high fields.
    assign tlb_flt = code >= FLT_MISS_FETCH;

    // Result address and cacheability, cleared on any fault.
    always_comb begin
        nx_paddr = '0;
        nx_unc   = 1'b0;
        if (code == FLT_NONE) begin
            nx_paddr = (in_kc || in_ku) ? direct_pa : mapped_pa;
            nx_unc   = addr_unc;
        end
    end

    // Response register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= '0;
            rsp_paddr    <= '0;
            rsp_uncached <= 1'b0;
            rsp_mode     <= '0;
            rsp_badva    <= '0;
            rsp_asid     <= '0;
            rsp_vpn2     <= '0;
            rsp_vpn2x    <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault    <= code;
                rsp_paddr    <= nx_paddr;
                rsp_uncached <= nx_unc;
                rsp_mode     <= mode;
                rsp_badva    <= (code != FLT_NONE) ? req_vaddr : '0;
                rsp_asid     <= tlb_flt ? req_asid : '0;
                rsp_vpn2     <= tlb_flt ? look_vpn[VPN_W-1:2] : '0;
                rsp_vpn2x    <= tlb_flt ? look_vpn[1:0] : '0;
            end
        end
    end
endmodule

// File: rtl/xlat_front_chk.sv
// Property checker for xlat_front, attached by bind.
module xlat_front_chk
    import xlat_pkg::*;
#(
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    parameter int SH_W   = 5,
    localparam int PA_W  = PFN_W + PAGE_LSB
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_vaddr,
    input logic [1:0]        req_kind,
    input logic              req_misal,
    input logic              small_pg,
    input logic [VPN_W-1:0]  look_vpn,
    input logic              rsp_valid,
    input logic [2:0]        rsp_fault,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              rsp_uncached,
    input logic [ASID_W-1:0] rsp_asid,
    input logic [VPN2_W-1:0] rsp_vpn2
);
    a_r3_coarse_vpn: assert property (@(posedge clk) disable iff (!rst_n)
        !small_pg |-> look_vpn[1:0] == 2'b00);

    a_r4_kuncached_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_vaddr[31:29] == 3'b101 |=>
        rsp_fault == 3'd0 && rsp_uncached &&
        rsp_paddr == PA_W'($past(req_vaddr) & 32'h1FFF_FFFF));

    a_r6_misal_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_misal && !req_vaddr[31] |=>
        (rsp_fault == 3'd1 || rsp_fault == 3'd2));

    a_r9_fetch_no_dirty_fault: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == 2'd0 |=> rsp_fault != 3'd7);

    a_r10_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault < 3'd3 |-> rsp_asid == '0 && rsp_vpn2 == '0);

    a_r12_fault_clears_pa: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 3'd0 |-> rsp_paddr == '0 && !rsp_uncached);

    a_r13_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(req_valid));
endmodule

bind xlat_front xlat_front_chk #(.ASID_W(ASID_W), .PFN_W(PFN_W), .SH_W(SH_W)) u_chk (.*);

// File: tb/xlat_front_test.sv
module xlat_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_misal = 1'b0;
    logic [7:0]  req_asid = '0;
    logic [31:0] status_word = '0;
    logic        small_pg = 1'b0;
    logic [20:0] look_vpn;
    logic        tlb_hit = 1'b0;
    logic [4:0]  tlb_shift = 5'd12;
    logic [31:0] tlb_offmask = 32'hFFF;
    logic [19:0] tlb_pfn_even = '0, tlb_pfn_odd = '0;
    logic        tlb_valid_even = 1'b0, tlb_valid_odd = 1'b0;
    logic        tlb_dirty_even = 1'b0, tlb_dirty_odd = 1'b0;
    logic        rsp_valid, rsp_uncached;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_paddr, rsp_badva;
    logic [1:0]  rsp_mode, rsp_vpn2x;
    logic [7:0]  rsp_asid;
    logic [18:0] rsp_vpn2;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    xlat_front uut (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic set_tlb(input logic hit, input logic [4:0] sh, input logic [31:0] om,
                           input logic [19:0] pe, input logic [19:0] po,
                           input logic ve, input logic vo, input logic de, input logic dd);
        tlb_hit = hit; tlb_shift = sh; tlb_offmask = om;
        tlb_pfn_even = pe; tlb_pfn_odd = po;
        tlb_valid_even = ve; tlb_valid_odd = vo;
        tlb_dirty_even = de; tlb_dirty_odd = dd;
    endtask

    // Drive one request and sample just after the capturing edge.
    task automatic issue(input logic [31:0] va, input logic [1:0] kind, input logic mis,
                         input logic [31:0] st, input logic sp);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_misal = mis;
        status_word = st; small_pg = sp;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 valid", rsp_valid, 0);
        chk("R1 fault", rsp_fault, 0);
        chk("R1 paddr", rsp_paddr, 0);
        chk("R1 badva", {rsp_badva, rsp_asid, rsp_vpn2, rsp_vpn2x, rsp_uncached}, 0);
    endtask

    task automatic t_mode;
        set_tlb(1, 12, 32'hFFF, 20'h1, 20'h1, 1, 1, 1, 1);
        issue(32'h0000_1000, 1, 0, 32'h0000_0000, 0); chk("R2 kernel", rsp_mode, 0);
        issue(32'h0000_1000, 1, 0, 32'h0000_0008, 0); chk("R2 super", rsp_mode, 1);
        issue(32'h0000_1000, 1, 0, 32'h0000_0010, 0); chk("R2 user", rsp_mode, 2);
        issue(32'h0000_1000, 1, 0, 32'h0000_0018, 0); chk("R2 undef", rsp_mode, 3);
        issue(32'h0000_1000, 1, 0, 32'h1000_0018, 0); chk("R2 override28", rsp_mode, 0);
        issue(32'h0000_1000, 1, 0, 32'h0000_0014, 0); chk("R2 override2", rsp_mode, 0);
    endtask

    task automatic t_lookup_vpn;
        req_vaddr = 32'h0040_5A34; small_pg = 1'b0; #1;
        chk("R3 coarse", look_vpn, 21'h808);
        small_pg = 1'b1; #1;
        chk("R3 small", look_vpn, 21'h80B);
        small_pg = 1'b0;
    endtask

    task automatic t_kseg_bypass;
        set_tlb(0, 12, 32'hFFF, 0, 0, 0, 0, 0, 0);
        issue(32'h8001_2345, 0, 0, 32'h0, 0);
        chk("R4 k0 fault", rsp_fault, 0);
        chk("R4 k0 pa", rsp_paddr, 32'h0001_2345);
        chk("R4 k0 cached", rsp_uncached, 0);
        issue(32'hA000_1001, 2, 1, 32'h10, 0);
        chk("R5 k1 no fault", rsp_fault, 0);
        chk("R4 k1 pa", rsp_paddr, 32'h0000_1001);
        chk("R4 k1 uncached", rsp_uncached, 1);
    endtask

    task automatic t_kseg0_err;
        issue(32'h8000_4000, 1, 0, 32'h10, 0);
        chk("R5 user data", rsp_fault, 2);
        chk("R5 badva", rsp_badva, 32'h8000_4000);
        chk("R12 fault pa", {rsp_paddr, rsp_uncached}, 0);
        issue(32'h8000_4002, 0, 1, 32'h0, 0);
        chk("R5 misal fetch", rsp_fault, 1);
        issue(32'h8000_4000, 1, 0, 32'h12, 0);
        chk("R5 exl kernel", rsp_fault, 0);
        issue(32'h8000_4000, 0, 0, 32'h18, 0);
        chk("R5 undef mode", rsp_fault, 1);
    endtask

    task automatic t_misal_mapped;
        set_tlb(0, 12, 32'hFFF, 0, 0, 0, 0, 0, 0);
        issue(32'h0040_3001, 1, 1, 32'h0, 0);
        chk("R6 misal miss", rsp_fault, 2);
        chk("R10 addr err fields", {rsp_asid, rsp_vpn2, rsp_vpn2x}, 0);
        chk("R6 badva", rsp_badva, 32'h0040_3001);
    endtask

    task automatic t_miss;
        set_tlb(0, 12, 32'hFFF, 0, 0, 0, 0, 0, 0);
        req_asid = 8'h5A;
        issue(32'h0040_3000, 1, 0, 32'h0, 0);
        chk("R7 data refill", rsp_fault, 4);
        chk("R10 asid", rsp_asid, 8'h5A);
        chk("R10 vpn2", rsp_vpn2, 19'h201);
        chk("R10 vpn2x coarse", rsp_vpn2x, 0);
        chk("R10 badva", rsp_badva, 32'h0040_3000);
        issue(32'h0040_3000, 0, 0, 32'h0, 1);
        chk("R7 fetch refill", rsp_fault, 3);
        chk("R10 vpn2x small", rsp_vpn2x, 2);
    endtask

    task automatic t_invalid;
        set_tlb(1, 12, 32'hFFF, 20'h11, 20'h22, 0, 1, 1, 1);
        issue(32'h0040_2A34, 0, 0, 32'h0, 0);
        chk("R8 even invalid fetch", rsp_fault, 5);
        issue(32'h0040_3A34, 1, 0, 32'h0, 0);
        chk("R8 odd valid", rsp_fault, 0);
        chk("R8 odd pa", rsp_paddr, 32'h0002_2A34);
        set_tlb(1, 12, 32'hFFF, 20'h11, 20'h22, 1, 0, 1, 1);
        issue(32'h0040_3A34, 2, 0, 32'h0, 0);
        chk("R8 odd invalid data", rsp_fault, 6);
        chk("R10 invalid vpn2", rsp_vpn2, 19'h201);
    endtask

    task automatic t_modified;
        set_tlb(1, 12, 32'hFFF, 20'h00ABC, 20'h0, 1, 1, 0, 1);
        issue(32'h0040_2A34, 2, 0, 32'h0, 0);
        chk("R9 write clean", rsp_fault, 7);
        issue(32'h0040_2A34, 1, 0, 32'h0, 0);
        chk("R9 read clean", rsp_fault, 0);
        chk("R11 even pa", rsp_paddr, 32'h00AB_CA34);
        issue(32'h0040_2A34, 0, 0, 32'h0, 0);
        chk("R9 fetch clean", rsp_fault, 0);
        set_tlb(1, 12, 32'hFFF, 20'h00ABC, 20'h0, 1, 1, 1, 1);
        issue(32'h0040_2A34, 2, 0, 32'h0, 0);
        chk("R9 write dirty", rsp_fault, 0);
    endtask

    task automatic t_paddr;
        set_tlb(1, 12, 32'hFFF, 20'h0, 20'h12345, 1, 1, 1, 1);
        issue(32'h0040_5A34, 1, 0, 32'h0, 0);
        chk("R11 4K odd", rsp_paddr, 32'h1234_5A34);
        set_tlb(1, 14, 32'h3FFF, 20'h0, 20'h12347, 1, 1, 1, 1);
        issue(32'h0040_6A34, 1, 0, 32'h0, 0);
        chk("R11 16K odd", rsp_paddr, 32'h1234_6A34);
        chk("R12 mapped cached", rsp_uncached, 0);
    endtask

    task automatic t_uncached_map;
        set_tlb(1, 12, 32'hFFF, 20'h00077, 20'h0, 1, 1, 1, 1);
        issue(32'hE000_0010, 1, 0, 32'h0, 0);
        chk("R12 top region fault", rsp_fault, 0);
        chk("R12 top region uncached", rsp_uncached, 1);
        chk("R11 top region pa", rsp_paddr, 32'h0007_7010);
    endtask

    task automatic t_idle;
        set_tlb(0, 12, 32'hFFF, 0, 0, 0, 0, 0, 0);
        issue(32'h0040_3000, 1, 0, 32'h0, 0);
        req_vaddr = 32'h8000_0000; status_word = 32'h10;
        @(posedge clk); #1;
        chk("R13 valid low", rsp_valid, 0);
        chk("R13 hold", rsp_fault, 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_mode;
        t_lookup_vpn;
        t_kseg_bypass;
        t_kseg0_err;
        t_misal_mapped;
        t_miss;
        t_invalid;
        t_modified;
        t_paddr;
        t_uncached_map;
        t_idle;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule